// File: doc/BRIEF.md
# Atomic Set/Clear Output Port Register

This block holds the output levels of a general-purpose port and lets software change them through a small memory-mapped register bus. Besides a plain data register that loads every bit at once, it offers two write-only strobe addresses. A write to the set strobe raises each output bit whose data bit is 1. A write to the clear strobe lowers each output bit whose data bit is 1. In both cases, bits written as 0 keep their current level.

Each bit is a clocked set/reset element. A single bus write therefore changes chosen bits without a preceding bus read. This means no interrupt can land between a read and a write and undo a concurrent change. The port width is a parameter, 8 by default. The write side is a single-cycle strobe with no back-pressure: every cycle with the write enable high commits, and the block never stalls. The read side is combinational.

Address map (the word offset on `bus_addr`): 0 is the data register (read/write), 1 is the set strobe, 2 is the clear strobe, and 3 is unmapped.

Top module: `gpio_setclr_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, `port_out` becomes all zeros on that edge, whatever the bus is doing.
- R2: A write with `bus_addr` = 0 loads `bus_wdata` into `port_out` on the same clock edge, so the new value is seen one cycle after the strobe.
- R3: A write with `bus_addr` = 1 forces to 1 every `port_out` bit whose `bus_wdata` bit is 1, and leaves every other bit unchanged.
- R4: A write with `bus_addr` = 2 forces to 0 every `port_out` bit whose `bus_wdata` bit is 1, and leaves every other bit unchanged.
- R5: When `bus_addr` is 0, 1 or 2, `bus_rdata` equals the current `port_out` in the same cycle, with no clock delay.
- R6: When `bus_addr` is 3, `bus_rdata` is all zeros.
- R7: A write with `bus_addr` = 3 has no effect on `port_out`.
- R8: In a cycle with `bus_we` low, `port_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (2) | Register word offset |
| bus_we | input | 1 | Write strobe; each high cycle performs one write |
| bus_wdata | input | WIDTH (8) | Write data or per-bit strobe mask |
| bus_rdata | output | WIDTH (8) | Read data for the addressed register |
| port_out | output | WIDTH (8) | Output pin levels |

## Verification
The hardest case to reach is a set or clear mask that partly overlaps bits already at the target level, so that the untouched bits must survive while others change. A port stuck at one pattern never shows this. The stimulus builds up varied port states with random full loads, then sends random masks to the set and clear strobes one after another. Directed cases add all-zero and all-ones masks, writes to the unmapped offset, and a reset in the middle of a run.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  // Word offsets of the register map
  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_SET  = 1;
  localparam int unsigned OFS_CLR  = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  j_vec,
  output logic [WIDTH-1:0]  k_vec,
  output logic              load,
  output logic              mapped
);
  import gpio_sc_pkg::*;

  wr_op_e op;

  always_comb begin
    mapped = 1'b1;
    op     = OP_NONE;
    if (addr == ADDR_W'(OFS_DATA))      op = we ? OP_LOAD : OP_NONE;
    else if (addr == ADDR_W'(OFS_SET))  op = we ? OP_SET  : OP_NONE;
    else if (addr == ADDR_W'(OFS_CLR))  op = we ? OP_CLR  : OP_NONE;
    else                                mapped = 1'b0;
  end

  always_comb begin
    j_vec = '0;
    k_vec = '0;
    load  = 1'b0;
    unique case (op)
      OP_LOAD: load  = 1'b1;
      OP_SET:  j_vec = wdata;
      OP_CLR:  k_vec = wdata;
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_sc_bitcell.sv
module gpio_sc_bitcell (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  input  logic j,
  input  logic k,
  output logic q
);
  logic q_nxt;

  always_comb begin
    unique case ({j, k})
      2'b10:   q_nxt = 1'b1;
      2'b01:   q_nxt = 1'b0;
      2'b11:   q_nxt = ~q;
      default: q_nxt = q;
    endcase
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/gpio_sc_readmux.sv
module gpio_sc_readmux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             mapped,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rdata
);
  always_comb rdata = mapped ? q : '0;
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  port_out
);
  logic [WIDTH-1:0] j_vec;
  logic [WIDTH-1:0] k_vec;
  logic             load;
  logic             mapped;

  gpio_sc_decode #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_decode (
    .addr   (bus_addr),
    .we     (bus_we),
    .wdata  (bus_wdata),
    .j_vec  (j_vec),
    .k_vec  (k_vec),
    .load   (load),
    .mapped (mapped)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    gpio_sc_bitcell u_cell (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (bus_wdata[b]),
      .j    (j_vec[b]),
      .k    (k_vec[b]),
      .q    (port_out[b])
    );
  end

  gpio_sc_readmux #(.WIDTH(WIDTH)) u_readmux (
    .mapped (mapped),
    .q      (port_out),
    .rdata  (bus_rdata)
  );
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  port_out
);
  logic is_map;
  assign is_map = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(1)) ||
                  (bus_addr == ADDR_W'(2));

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> port_out == '0);

  // R2
  load_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(0)) |=> port_out == $past(bus_wdata));

  // R3
  set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(1)) |=>
      port_out == ($past(port_out) | $past(bus_wdata)));

  // R4
  clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(2)) |=>
      port_out == ($past(port_out) & ~$past(bus_wdata)));

  // R5
  read_mapped_chk: assert property (@(posedge clk) disable iff (rst)
    is_map |-> bus_rdata == port_out);

  // R6
  read_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    !is_map |-> bus_rdata == '0);

  // R7
  hole_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !is_map) |=> $stable(port_out));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> $stable(port_out));
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .port_out  (port_out)
);

// File: tb/gpio_setclr_port_bench.sv
module gpio_setclr_port_bench;
  localparam int W  = 8;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  port_out;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] exp_q = '0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_setclr_port #(.WIDTH(W), .ADDR_W(AW)) u_gpio_setclr_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_out(port_out)
  );

  function automatic logic [W-1:0] next_val(logic [W-1:0] cur, logic [AW-1:0] a,
                                            logic [W-1:0] d);
    case (a)
      2'd0:    return d;          // R2
      2'd1:    return cur | d;    // R3
      2'd2:    return cur & ~d;   // R4
      default: return cur;        // R7
    endcase
  endfunction

  function automatic logic [W-1:0] read_val(logic [W-1:0] cur, logic [AW-1:0] a);
    return (a == 2'd3) ? '0 : cur;  // R5 / R6
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, expv);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [W-1:0] d, string req);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    exp_q = next_val(exp_q, a, d);
    @(negedge clk);
    bus_we = 1'b0;
    chk(req, port_out, exp_q);
  endtask

  task automatic do_read(logic [AW-1:0] a, string req);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 chk(req, bus_rdata, read_val(exp_q, a));
  endtask

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q = '0;
    chk("R1 reset state", port_out, '0);

    do_write(2'd0, 8'hA5, "R2 load");
    do_write(2'd1, 8'h0F, "R3 set partial");
    do_write(2'd1, 8'h00, "R3 set zero mask");
    do_write(2'd2, 8'h81, "R4 clear partial");
    do_write(2'd2, 8'h00, "R4 clear zero mask");
    do_write(2'd3, 8'hFF, "R7 unmapped write");
    do_read(2'd1, "R5 read set offset");
    do_read(2'd2, "R5 read clear offset");
    do_read(2'd0, "R5 read data");
    do_read(2'd3, "R6 unmapped read");
    do_write(2'd1, 8'hFF, "R3 set all");
    do_write(2'd2, 8'hFF, "R4 clear all");
    do_write(2'd0, 8'h3C, "R2 load again");
    repeat (4) @(negedge clk);
    chk("R8 idle hold", port_out, exp_q);

    // R1: reset mid-run overrides a write in the same cycle
    @(negedge clk);
    rst = 1'b1; bus_addr = 2'd1; bus_we = 1'b1; bus_wdata = 8'hFF;
    @(negedge clk);
    rst = 1'b0; bus_we = 1'b0;
    exp_q = '0;
    chk("R1 reset during write", port_out, '0);

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d;
      a = AW'($urandom_range(0, 3));
      d = W'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        do_read(a, (a == 2'd3) ? "R6 random read" : "R5 random read");
      end else begin
        case (a)
          2'd0: do_write(a, d, "R2 random load");
          2'd1: do_write(a, d, "R3 random set");
          2'd2: do_write(a, d, "R4 random clear");
          default: do_write(a, d, "R7 random unmapped");
        endcase
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule